// File: doc/BRIEF.md
# Serial EEPROM Bus Slave with Write-Protect Cancel

This block is the control side of a byte-addressed serial EEPROM on a two-wire I2C bus. SCL, SDA and the write-protect pin come in asynchronously. Each is passed through a synchroniser, and the block sees SCL edges and START/STOP conditions as single-cycle events on the system clock. The block answers a device address made of the fixed code `1010`, three strap pins and a read/write bit. It then takes a two-byte word address into a 14-bit pointer. After that it either buffers write data in a page buffer or streams read data out of an internal synchronous RAM.

Written bytes are held in the page buffer until a STOP arrives. The STOP starts a timed internal write cycle of `TWR_CLKS` system clocks, during which the buffered bytes are copied into the array. The device address is not acknowledged while that cycle runs, so a master can poll for completion. Write-protect is watched from the clock that captures the last bit of the first data byte until the write cycle ends. If it is raised before the cycle starts, the write is dropped. If it is raised during the cycle, the cycle stops at once.

SDA is an open-drain line. The block only pulls it low, through `sda_oe`. The bus has its own wired-AND flow control, so it has no valid/ready interface. The array holds 2^`ARRAY_AW` bytes and is indexed by the low `ARRAY_AW` bits of the 14-bit pointer. Above that depth, addresses alias.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and no write cycle is running, so the first correct device address is acknowledged.
- R2: A START clears bit and byte framing, even in the middle of a byte. After a device address that is not acknowledged, every further byte is left unacknowledged until the next START.
- R3: A device byte is acknowledged only if bits [7:4] are `1010` and bits [3:1] equal `strap_i`. Bit 0 is 1 for read and 0 for write. Acknowledge means SDA is held low through the ninth SCL clock.
- R4: A write transfer sends the word address high byte, then the low byte, and each byte is acknowledged. Bits [7:6] of the high byte are ignored.
- R5: The block changes `sda_oe` only after an SCL falling edge. It never changes it while SCL is high. Data leaves MSB first.
- R6: Data bytes go into a 64-byte page buffer. The low 6 pointer bits wrap inside the page and the upper bits stay fixed. A STOP starts the write cycle only when at least one data byte has been received. A STOP after the address alone only sets the pointer, and a following read starts there.
- R7: For `TWR_CLKS` clocks after the STOP that starts a write, the device address is not acknowledged. After that time it is acknowledged again.
- R8: A read returns the byte at the pointer, and each byte increments the full 14-bit pointer, wrapping 0x3FFF to 0x0000. A master ACK fetches the next byte. A master NACK and then a STOP end the transfer with SDA released.
- R9: If write-protect is high at any point from the capture of the first data byte's last bit until the STOP, the write is cancelled. No write cycle starts, the device is acknowledged at once, and memory is unchanged.
- R10: If write-protect goes high during the write cycle, the cycle ends within a few clocks and the device acknowledges again. The page being written is then undefined.
- R11: A repeated START during write data throws the buffered bytes away and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Device-select strap pins, compared with device byte bits [3:1] |
| wp_i | input | 1 | Write-protect, active high, asynchronous |

## Verification
Faults in the framing counter or the state register show up in the ninth clock of the very next byte, as a missing or extra acknowledge. A wrong pointer or page-wrap step stays hidden until the locations are read back, and then it shows as wrong data in the byte that follows the bad step. Faults in the write-cycle timer or the write-protect window show through acknowledge polling. They appear either as a NACK right after a STOP that should have started nothing, or as an ACK before `TWR_CLKS` has run out. A cancelled write that still changes memory shows as changed data on the next read.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int WADDR_W = 14;
  localparam int SEL_W   = 3;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } eep_state_e;
endpackage

// File: rtl/eep_bus_front.sv
module eep_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q, wp_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      wp_q  <= '0;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      wp_q  <= {wp_q[SYNC_STAGES-2:0], wp_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign wp_s      = wp_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int TWR_CLKS    = 2000,
  parameter int PAGE_AW     = 6,
  parameter int ARRAY_AW    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             wp_i
);
  localparam int PAGE  = 2 ** PAGE_AW;
  localparam int TMR_W = $clog2(TWR_CLKS + 1);

  logic sda_s, wp_s, scl_rise, scl_fall, start_evt, stop_evt;

  eep_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .sda_s(sda_s), .wp_s(wp_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_state_e         st, st_nx;
  logic [3:0]         bitcnt;
  logic [7:0]         sr;
  logic [WADDR_W-1:0] waddr;
  logic               have_data, armed, kill, busy;
  logic [TMR_W-1:0]   tmr;
  logic [PAGE_AW:0]   ptr;
  logic [PAGE-1:0]    pvalid;
  logic [7:0]         pbuf [PAGE];
  logic [7:0]         mem_q;
  logic               dev_ok, byte_end, ack_rise, buf_we, ptr_act, mem_we;

  assign dev_ok   = (sr[7:4] == DEV_CODE) && (sr[3:1] == strap_i) && !busy;
  assign byte_end = scl_fall && (bitcnt == 4'd8);
  assign ack_rise = scl_rise && (bitcnt == 4'd8);
  assign buf_we   = byte_end && (st == ST_WDAT);
  assign ptr_act  = busy && !ptr[PAGE_AW];
  assign mem_we   = ptr_act && pvalid[ptr[PAGE_AW-1:0]];

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[waddr[PAGE_AW-1:0]] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; st_nx <= ST_IDLE; bitcnt <= '0; sr <= '0; waddr <= '0;
      sda_oe <= 1'b0; have_data <= 1'b0; armed <= 1'b0; kill <= 1'b0;
      busy <= 1'b0; tmr <= '0; ptr <= '0; pvalid <= '0;
    end else begin
      // internal write cycle: copy page, abort on write-protect
      if (busy) begin
        if (wp_s) busy <= 1'b0;
        else if (tmr == TMR_W'(TWR_CLKS - 1)) busy <= 1'b0;
        tmr <= tmr + TMR_W'(1);
        if (ptr_act) ptr <= ptr + (PAGE_AW+1)'(1);
      end
      if (start_evt || stop_evt) begin
        bitcnt <= '0; sda_oe <= 1'b0;
        have_data <= 1'b0; armed <= 1'b0; kill <= 1'b0;
        st <= start_evt ? ST_DEV : ST_IDLE;
        if (stop_evt && st == ST_WDAT && have_data && !kill && !wp_s) begin
          busy <= 1'b1; tmr <= '0; ptr <= '0;
        end
      end else begin
        if (armed && wp_s) kill <= 1'b1;
        if (scl_rise) begin
          if (bitcnt != 4'd8) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7 && st == ST_WDAT) armed <= 1'b1;
          end else begin
            bitcnt <= '0;
            if (st == ST_RDAT) begin
              waddr <= waddr + WADDR_W'(1);
              if (sda_s) st <= ST_IDLE;
            end else begin
              st <= st_nx;
            end
          end
        end
        if (byte_end) begin
          sda_oe <= 1'b1;
          st_nx  <= st;
          case (st)
            ST_DEV: begin
              sda_oe <= dev_ok;
              st_nx  <= !dev_ok ? ST_IDLE : (sr[0] ? ST_RDAT : ST_AHI);
            end
            ST_AHI: begin
              waddr[WADDR_W-1:8] <= sr[WADDR_W-9:0];
              st_nx <= ST_ALO;
            end
            ST_ALO: begin
              waddr[7:0] <= sr;
              pvalid     <= '0;
              st_nx      <= ST_WDAT;
            end
            ST_WDAT: begin
              pvalid[waddr[PAGE_AW-1:0]] <= 1'b1;
              waddr[PAGE_AW-1:0] <= waddr[PAGE_AW-1:0] + PAGE_AW'(1);
              have_data <= 1'b1;
            end
            default: begin
              sda_oe <= 1'b0;
              st_nx  <= (st == ST_RDAT) ? ST_RDAT : ST_IDLE;
            end
          endcase
        end else if (scl_fall) begin
          sda_oe <= (st == ST_RDAT) ? ~mem_q[3'd7 - bitcnt[2:0]] : 1'b0;
        end
      end
    end
  end

  eep_array #(.AW(ARRAY_AW), .DW(8)) u_array (
    .clk(clk),
    .we(mem_we),
    .waddr({waddr[ARRAY_AW-1:PAGE_AW], ptr[PAGE_AW-1:0]}),
    .wdata(wp_s ? ~pbuf[ptr[PAGE_AW-1:0]] : pbuf[ptr[PAGE_AW-1:0]]),
    .raddr(waddr[ARRAY_AW-1:0]),
    .rdata(mem_q)
  );

  // R5: SDA drive moves only after a falling SCL edge or a bus condition
  a_r5_sda_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R7: device address never acknowledged while the write cycle runs
  a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && st == ST_DEV && busy) |=> !sda_oe);

  // R6: a write cycle starts only from a STOP after received data
  a_r6_write_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt && have_data));

  // R9: a cancelled transfer never starts the write cycle
  a_r9_cancel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && kill) |=> !busy);

  // R10: write-protect during the cycle ends it on the next clock
  a_r10_abort_now: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp_s) |=> !busy);

  // R2: framing counter stays within a byte plus its acknowledge slot
  a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

// File: tb/eep_i2c_slave_bench.sv
module eep_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int TWR        = 1000;
  localparam int ARRAY_AW   = 11;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, line;
  assign line = sda_m & ~sda_oe;

  eep_i2c_slave #(.TWR_CLKS(TWR), .PAGE_AW(6), .ARRAY_AW(ARRAY_AW), .SYNC_STAGES(2)) u_eep_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .strap_i(strap), .wp_i(wp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, viol = 0, hi_cnt = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [int];
  logic [7:0] wq [$];
  logic [7:0] devw, devr;

  // every clock: SDA drive must not move during a settled SCL high phase
  always @(negedge clk) begin
    hi_cnt <= scl ? hi_cnt + 1 : 0;
    if (hi_cnt >= 5 && sda_oe != prev_oe) viol <= viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int akey(input int a);
    return (a & 16'h3FFF) & ((1 << ARRAY_AW) - 1);
  endfunction

  task automatic bit_xfer(input logic tx, output logic rx);
    sda_m = tx; wait_clk(Q); scl = 1'b1; wait_clk(Q);
    rx = line; wait_clk(Q); scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q); scl = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q); scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q); scl = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      b[i] = r;
    end
    bit_xfer(~mack, r);
  endtask

  task automatic poll(output logic ack);
    bus_start(); send_byte(devw, ack); bus_stop();
  endtask

  task automatic do_write(input int a, input bit cancel);
    logic ack;
    logic [13:0] ad;
    ad = a[13:0];
    bus_start();
    send_byte(devw, ack);                 chk(ack, "R3 write select", ack, 1);
    send_byte(8'hC0 | {2'b00, ad[13:8]}, ack); chk(ack, "R4 addr hi", ack, 1);
    send_byte(ad[7:0], ack);              chk(ack, "R4 addr lo", ack, 1);
    foreach (wq[i]) begin
      send_byte(wq[i], ack);              chk(ack, "R6 data ack", ack, 1);
      if (i == 0 && cancel) wp = 1'b1;
    end
    bus_stop();
    wp = 1'b0;
    if (!cancel)
      foreach (wq[i]) model[akey((a & ~63) | ((a + i) & 63))] = wq[i];
  endtask

  task automatic read_at(input int a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    logic [13:0] ad;
    ad = a[13:0];
    bus_start();
    send_byte(devw, ack);
    send_byte({2'b00, ad[13:8]}, ack);
    send_byte(ad[7:0], ack);
    bus_start();
    send_byte(devr, ack);                 chk(ack, "R3 read select", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b === model[akey(a + i)], req, b, model[akey(a + i)]);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
  endtask

  initial begin
    wait_clk(190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    devw = {4'b1010, strap, 1'b0};
    devr = {4'b1010, strap, 1'b1};
    wait_clk(10);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wait_clk(10);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    poll(ack); chk(ack, "R1 idle ack", ack, 1);

    // R3 / R2: wrong strap, then ignored byte until START
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, ack); chk(!ack, "R3 strap mismatch", ack, 0);
    send_byte(devw, ack);                    chk(!ack, "R2 ignored until START", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b0110, strap, 1'b0}, ack);  chk(!ack, "R3 code mismatch", ack, 0);
    bus_stop();

    // R2: START cuts a half byte
    bus_start();
    bit_xfer(1'b1, b[0]); bit_xfer(1'b0, b[0]); bit_xfer(1'b1, b[0]); bit_xfer(1'b0, b[0]);
    bus_start();
    send_byte(devw, ack); chk(ack, "R2 restart mid byte", ack, 1);
    bus_stop();

    // R7 / R4: basic write, polling, read back
    wq = {8'h5A, 8'hC3, 8'h01, 8'hFE, 8'h77};
    do_write(16'h0123, 1'b0);
    poll(ack); chk(!ack, "R7 busy nack", ack, 0);
    wait_clk(TWR + 50);
    poll(ack); chk(ack, "R7 ack after tWR", ack, 1);
    read_at(16'h0123, 5, "R4 read back");

    // R6: page wrap
    wq = {8'hA1, 8'hA2, 8'hA3};
    do_write(16'h0A3E, 1'b0);
    wait_clk(TWR + 50);
    read_at(16'h0A00, 1, "R6 wrapped byte");
    read_at(16'h0A3E, 2, "R6 page tail");

    // R8: full pointer wrap
    wq = {8'h7E}; do_write(16'h3FFF, 1'b0); wait_clk(TWR + 50);
    wq = {8'h81}; do_write(16'h0000, 1'b0); wait_clk(TWR + 50);
    read_at(16'h3FFF, 2, "R8 pointer wrap");

    // R6: STOP after address only
    bus_start();
    send_byte(devw, ack); send_byte(8'h01, ack); send_byte(8'h24, ack);
    bus_stop();
    poll(ack); chk(ack, "R6 no cycle without data", ack, 1);
    bus_start();
    send_byte(devr, ack);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b === model[akey(16'h0124)], "R6 current address read", b, model[akey(16'h0124)]);

    // R9: write-protect cancel
    wq = {8'h11, 8'h22}; do_write(16'h0300, 1'b0); wait_clk(TWR + 50);
    wq = {8'hEE, 8'hFF}; do_write(16'h0300, 1'b1);
    poll(ack); chk(ack, "R9 cancel leaves idle", ack, 1);
    read_at(16'h0300, 2, "R9 memory unchanged");

    // R11: repeated START discards page
    bus_start();
    send_byte(devw, ack); send_byte(8'h03, ack); send_byte(8'h00, ack);
    send_byte(8'h99, ack);
    bus_start();
    send_byte(devr, ack); chk(ack, "R11 no cycle on restart", ack, 1);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b === model[akey(16'h0301)], "R11 pointer advanced", b, model[akey(16'h0301)]);
    poll(ack); chk(ack, "R11 still idle", ack, 1);
    read_at(16'h0300, 1, "R11 data discarded");

    // R10: write-protect abort during tWR
    wq = {8'h33, 8'h44}; do_write(16'h0400, 1'b0);
    wait_clk(200);
    wp = 1'b1; wait_clk(6); wp = 1'b0;
    poll(ack); chk(ack, "R10 abort ends cycle", ack, 1);
    model.delete(akey(16'h0400)); model.delete(akey(16'h0401));
    wait_clk(TWR);

    chk(viol == 0, "R5 no SDA change while SCL high", viol, 0);
    finish_run();
  end
endmodule